// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the sequence of bus-word addresses for one memory-side DMA transfer shaped as a rectangle. The request gives a start address, the row length in bytes, the number of rows and the distance in bytes between the starts of consecutive rows. The generator walks each row one bus word at a time. It then moves the row base on by the stride and repeats the walk for every row. Each address is offered on a ready/valid handshake, and the downstream bus master takes it when it can.

A start pulse loads the request in the same cycle that the fields are presented. A request that would produce a misaligned beat is refused with a one-cycle reject pulse. A finished transfer gives a one-cycle done pulse. In cyclic mode the pattern starts again from the first row with no software action and never reports done. An abort input stops the walk at once. The address of the current beat can be read on the output at all times during a transfer.

Top module: `agen2d`

## Requirements
- R1: After reset, `beat_valid_o`, `done_o` and `reject_o` are low and `addr_o` is zero.
- R2: An accepted start while idle raises `beat_valid_o` in the next cycle, with `addr_o` equal to the start address.
- R3: The row length field holds the row byte count minus one. A row has (field+1)/BUS_BYTES beats, and each beat address is the previous one plus BUS_BYTES. Every offered address is aligned to BUS_BYTES.
- R4: The row count field holds the number of rows minus one. Row k starts at start + k × stride, so the whole transfer covers X × Y bytes.
- R5: While `beat_valid_o` is high and `beat_ready_i` is low, `addr_o` and `beat_valid_o` hold their values.
- R6: In the cycle after the last beat is accepted in non-cyclic mode, `done_o` is high for exactly one cycle and `beat_valid_o` is low.
- R7: In cyclic mode, the beat that follows the last beat of the last row is the start address again, and `done_o` stays low.
- R8: A start is rejected if the start address is not a multiple of BUS_BYTES, the row byte count is not a multiple of BUS_BYTES, or the stride is not a multiple of BUS_BYTES. A rejected start gives a one-cycle `reject_o` pulse in the next cycle and no beats.
- R9: A start pulse while a transfer is in progress is ignored. The offered address does not change and no reject is raised.
- R10: When `abort_i` is high at a clock edge, `beat_valid_o` is low from the next cycle on and no done pulse follows. A new start afterwards works normally.
- R11: `row_end_o` is high on the final beat of each row. `xfer_end_o` is high only on the final beat of the final row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; loads the request fields |
| start_addr_i | input | ADDR_W | First byte address |
| x_len_m1_i | input | XLEN_W | Row length in bytes, minus one |
| y_len_m1_i | input | YLEN_W | Row count, minus one |
| stride_i | input | ADDR_W | Byte distance between row starts |
| cyclic_i | input | 1 | Repeat the pattern without end |
| abort_i | input | 1 | Return to idle |
| beat_ready_i | input | 1 | Downstream accepts the offered address |
| beat_valid_o | output | 1 | An address is offered (also the busy indication) |
| addr_o | output | ADDR_W | Current beat address |
| row_end_o | output | 1 | Offered beat is the last of its row |
| xfer_end_o | output | 1 | Offered beat is the last of the pattern |
| done_o | output | 1 | One-cycle pulse after the final beat |
| reject_o | output | 1 | One-cycle pulse for a refused start |

## Verification
Every result is registered, so it appears one clock edge after its cause. After a start, the first address, a reject pulse or the unchanged state of a refused start shows in the next cycle. The address after an accepted beat, the done pulse after the final accept and the idle state after an abort also show one edge later. The bench drives inputs on falling edges and checks outputs at the next falling edge, exactly one rising edge after the stimulus. For stalled beats it adds one extra falling edge with ready low and checks that nothing moved. Expected addresses come from start, stride and bus width computed in the bench, row by row.

// File: rtl/agen2d_pkg.sv
package agen2d_pkg;

  typedef enum logic {
    AG_IDLE = 1'b0,
    AG_RUN  = 1'b1
  } ag_state_e;

endpackage

// File: rtl/agen2d_req_check.sv
// Decides whether a request yields only aligned beats and derives the
// per-row beat count (minus one) from the byte length field.
module agen2d_req_check #(
  parameter int ADDR_W    = 32,
  parameter int XLEN_W    = 16,
  parameter int BUS_BYTES = 8
) (
  input  logic [ADDR_W-1:0]                       addr_i,
  input  logic [ADDR_W-1:0]                       stride_i,
  input  logic [XLEN_W-1:0]                       x_len_m1_i,
  output logic                                    ok_o,
  output logic [XLEN_W-$clog2(BUS_BYTES)-1:0]     beats_m1_o
);
  localparam int OFS_W = $clog2(BUS_BYTES);

  generate
    if (OFS_W == 0) begin : g_byte_bus
      assign ok_o = 1'b1;
    end else begin : g_word_bus
      logic addr_al, stride_al, len_al;
      always_comb begin
        addr_al   = (addr_i[OFS_W-1:0] == '0);
        stride_al = (stride_i[OFS_W-1:0] == '0);
        // byte count = field + 1 is a whole number of words when the
        // low bits of the field are all ones
        len_al    = &x_len_m1_i[OFS_W-1:0];
        ok_o      = addr_al & stride_al & len_al;
      end
    end
  endgenerate

  assign beats_m1_o = x_len_m1_i[XLEN_W-1:OFS_W];

endmodule

// File: rtl/agen2d_down_ctr.sv
// Loadable down counter with a zero flag.
module agen2d_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/agen2d_addr_path.sv
// Row base and beat address registers. Row steps add the stride to the
// kept row base, so no multiplier is needed.
module agen2d_addr_path #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              col_step_i,
  input  logic              row_step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] WORD_INC = ADDR_W'(BUS_BYTES);

  logic [ADDR_W-1:0] row_base_q, row_base_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              path_en;
  logic [ADDR_W-1:0] next_row;

  always_comb begin
    next_row   = row_base_q + stride_i;
    path_en    = load_i | col_step_i | row_step_i;
    row_base_d = row_base_q;
    addr_d     = addr_q;
    if (load_i) begin
      row_base_d = base_i;
      addr_d     = base_i;
    end else if (row_step_i) begin
      row_base_d = next_row;
      addr_d     = next_row;
    end else if (col_step_i) begin
      addr_d     = addr_q + WORD_INC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_base_q <= '0;
      addr_q     <= '0;
    end else if (path_en) begin
      row_base_q <= row_base_d;
      addr_q     <= addr_d;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/agen2d.sv
module agen2d #(
  parameter int ADDR_W    = 32,
  parameter int XLEN_W    = 16,
  parameter int YLEN_W    = 16,
  parameter int BUS_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [XLEN_W-1:0] x_len_m1_i,
  input  logic [YLEN_W-1:0] y_len_m1_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              cyclic_i,
  input  logic              abort_i,
  input  logic              beat_ready_i,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              row_end_o,
  output logic              xfer_end_o,
  output logic              done_o,
  output logic              reject_o
);
  import agen2d_pkg::*;

  localparam int OFS_W  = $clog2(BUS_BYTES);
  localparam int BEAT_W = XLEN_W - OFS_W;

  ag_state_e         state_q, state_d;
  logic [ADDR_W-1:0] base_q, stride_q;
  logic [BEAT_W-1:0] beats_m1_q, beats_m1_w, col_cnt;
  logic [YLEN_W-1:0] rows_m1_q, row_cnt;
  logic              cyclic_q;
  logic              done_q, done_d, reject_q, reject_d;
  logic              req_ok, col_zero, row_zero;
  logic              running, idle_start, go, accept, eor, eot, rewind;
  logic              col_load, col_dec, row_load, row_dec, path_load;
  logic [BEAT_W-1:0] col_load_val;
  logic [YLEN_W-1:0] row_load_val;
  logic [ADDR_W-1:0] path_base, path_stride;

  agen2d_req_check #(
    .ADDR_W(ADDR_W), .XLEN_W(XLEN_W), .BUS_BYTES(BUS_BYTES)
  ) u_check (
    .addr_i    (start_addr_i),
    .stride_i  (stride_i),
    .x_len_m1_i(x_len_m1_i),
    .ok_o      (req_ok),
    .beats_m1_o(beats_m1_w)
  );

  // next-state and control
  always_comb begin
    running    = (state_q == AG_RUN);
    idle_start = (state_q == AG_IDLE) & start_i & ~abort_i;
    go         = idle_start & req_ok;
    accept     = running & beat_ready_i & ~abort_i;
    eor        = running & col_zero;
    eot        = eor & row_zero;
    rewind     = accept & eot & cyclic_q;

    col_load     = go | (accept & eor);
    col_dec      = accept & ~eor;
    col_load_val = go ? beats_m1_w : beats_m1_q;
    row_load     = go | rewind;
    row_dec      = accept & eor & ~eot;
    row_load_val = go ? y_len_m1_i : rows_m1_q;
    path_load    = go | rewind;
    path_base    = go ? start_addr_i : base_q;
    path_stride  = stride_q;

    done_d   = accept & eot & ~cyclic_q;
    reject_d = idle_start & ~req_ok;

    state_d = state_q;
    if (abort_i) begin
      state_d = AG_IDLE;
    end else if (go) begin
      state_d = AG_RUN;
    end else if (done_d) begin
      state_d = AG_IDLE;
    end
  end

  agen2d_down_ctr #(.W(BEAT_W)) u_col_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (col_load),
    .load_val_i(col_load_val),
    .dec_i     (col_dec),
    .cnt_o     (col_cnt),
    .zero_o    (col_zero)
  );

  agen2d_down_ctr #(.W(YLEN_W)) u_row_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (row_load),
    .load_val_i(row_load_val),
    .dec_i     (row_dec),
    .cnt_o     (row_cnt),
    .zero_o    (row_zero)
  );

  agen2d_addr_path #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (path_load),
    .base_i    (path_base),
    .stride_i  (path_stride),
    .col_step_i(col_dec),
    .row_step_i(row_dec),
    .addr_o    (addr_o)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= AG_IDLE;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      reject_q <= reject_d;
    end
  end

  // request registers, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      stride_q   <= '0;
      beats_m1_q <= '0;
      rows_m1_q  <= '0;
      cyclic_q   <= 1'b0;
    end else if (go) begin
      base_q     <= start_addr_i;
      stride_q   <= stride_i;
      beats_m1_q <= beats_m1_w;
      rows_m1_q  <= y_len_m1_i;
      cyclic_q   <= cyclic_i;
    end
  end

  logic unused_cnt;
  assign unused_cnt = ^{col_cnt, row_cnt};

  assign beat_valid_o = running;
  assign row_end_o    = eor;
  assign xfer_end_o   = eot;
  assign done_o       = done_q;
  assign reject_o     = reject_q;

endmodule

// File: rtl/agen2d_chk.sv
module agen2d_chk #(
  parameter int ADDR_W    = 32,
  parameter int XLEN_W    = 16,
  parameter int YLEN_W    = 16,
  parameter int BUS_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              abort_i,
  input logic              beat_ready_i,
  input logic              beat_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              xfer_end_o,
  input logic              done_o,
  input logic              reject_o
);
  localparam int OFS_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BUS_BYTES - 1);

  assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_ready_i && !abort_i) |=> (beat_valid_o && $stable(addr_o)));

  assert_beat_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o |-> ((addr_o & ALIGN_MASK) == '0));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(beat_valid_o && beat_ready_i && xfer_end_o) && !beat_valid_o));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!beat_valid_o && !done_o));

  assert_reject_no_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> !beat_valid_o);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && start_i) |=> !reject_o);

endmodule

bind agen2d agen2d_chk #(
  .ADDR_W(ADDR_W), .XLEN_W(XLEN_W), .YLEN_W(YLEN_W), .BUS_BYTES(BUS_BYTES)
) u_chk (.*);

// File: tb/sim_agen2d.sv
`timescale 1ns/1ps
module sim_agen2d;
  localparam int AW = 32;
  localparam int BB = 8;

  logic          clk, rst_n;
  logic          start_i, cyclic_i, abort_i, beat_ready_i;
  logic [AW-1:0] start_addr_i, stride_i;
  logic [15:0]   x_len_m1_i, y_len_m1_i;
  logic          beat_valid_o, row_end_o, xfer_end_o, done_o, reject_o;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;

  agen2d u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .x_len_m1_i(x_len_m1_i), .y_len_m1_i(y_len_m1_i), .stride_i(stride_i),
    .cyclic_i(cyclic_i), .abort_i(abort_i), .beat_ready_i(beat_ready_i),
    .beat_valid_o(beat_valid_o), .addr_o(addr_o), .row_end_o(row_end_o),
    .xfer_end_o(xfer_end_o), .done_o(done_o), .reject_o(reject_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // stimulus table: start, row bytes-1, rows-1, stride, stall pattern
  localparam int NV = 4;
  localparam int unsigned VA[NV] = '{32'h1000, 32'h2008, 32'h3000, 32'hFFF0};
  localparam int unsigned VX[NV] = '{15, 7, 31, 23};
  localparam int unsigned VY[NV] = '{2, 3, 0, 1};
  localparam int unsigned VS[NV] = '{32'h100, 32'h40, 32'h0, 32'h18};
  localparam int unsigned VT[NV] = '{0, 1, 1, 0};

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input int unsigned a, input int unsigned x, input int unsigned y,
                        input int unsigned s, input bit cyc);
    start_addr_i = a; x_len_m1_i = 16'(x); y_len_m1_i = 16'(y);
    stride_i = s; cyclic_i = cyc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic walk(input int unsigned a, input int unsigned x, input int unsigned y,
                      input int unsigned s, input bit stall);
    int unsigned beats = (x + 1) / BB;
    for (int r = 0; r <= int'(y); r++) begin
      for (int c = 0; c < int'(beats); c++) begin
        logic [AW-1:0] e;
        e = AW'(a + r * s + c * BB);
        if (stall && ((r + c) % 2 == 0)) begin
          beat_ready_i = 1'b0;
          @(negedge clk);
          chk(beat_valid_o && addr_o == e, "R5 stall hold", addr_o, e);
        end
        beat_ready_i = 1'b1;
        chk(beat_valid_o, "R2 valid", AW'(beat_valid_o), 1);
        chk(addr_o == e, (r == 0 && c == 0) ? "R2 first addr" :
            (c == 0) ? "R4 row start" : "R3 column step", addr_o, e);
        chk(row_end_o == (c == int'(beats) - 1) &&
            xfer_end_o == (c == int'(beats) - 1 && r == int'(y)),
            "R11 end flags", AW'({row_end_o, xfer_end_o}),
            AW'({c == int'(beats) - 1, c == int'(beats) - 1 && r == int'(y)}));
        @(negedge clk);
      end
    end
    beat_ready_i = 1'b0;
    chk(done_o && !beat_valid_o, "R6 done after last", AW'({done_o, beat_valid_o}), 2);
    @(negedge clk);
    chk(!done_o, "R6 done one cycle", AW'(done_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; cyclic_i = 1'b0; abort_i = 1'b0;
    beat_ready_i = 1'b0; start_addr_i = '0; stride_i = '0;
    x_len_m1_i = '0; y_len_m1_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!beat_valid_o && !done_o && !reject_o && addr_o == '0, "R1 reset state",
        addr_o, 0);

    // table of transfers
    for (int v = 0; v < NV; v++) begin
      launch(VA[v], VX[v], VY[v], VS[v], 1'b0);
      walk(VA[v], VX[v], VY[v], VS[v], VT[v][0]);
    end

    // R8: misaligned start address
    launch(32'h1004, 15, 0, 32'h40, 1'b0);
    chk(reject_o && !beat_valid_o, "R8 bad address", AW'({reject_o, beat_valid_o}), 2);
    @(negedge clk);
    chk(!reject_o && !beat_valid_o, "R8 reject one cycle", AW'({reject_o, beat_valid_o}), 0);
    // R8: row length not a whole number of words
    launch(32'h1000, 11, 0, 32'h40, 1'b0);
    chk(reject_o && !beat_valid_o, "R8 bad length", AW'({reject_o, beat_valid_o}), 2);
    @(negedge clk);
    // R8: misaligned stride
    launch(32'h1000, 15, 1, 32'h42, 1'b0);
    chk(reject_o && !beat_valid_o, "R8 bad stride", AW'({reject_o, beat_valid_o}), 2);
    @(negedge clk);

    // R9: start while busy has no effect
    launch(32'h7000, 15, 1, 32'h80, 1'b0);
    start_addr_i = 32'h9000; x_len_m1_i = 16'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(beat_valid_o && addr_o == 32'h7000 && !reject_o, "R9 busy start ignored",
        addr_o, 32'h7000);
    walk(32'h7000, 15, 1, 32'h80, 1'b0);

    // R10: abort mid-transfer
    launch(32'h5000, 15, 1, 32'h80, 1'b0);
    beat_ready_i = 1'b1;
    @(negedge clk);
    beat_ready_i = 1'b0;
    chk(addr_o == 32'h5008, "R3 step before abort", addr_o, 32'h5008);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(!beat_valid_o && !done_o, "R10 abort idle", AW'({beat_valid_o, done_o}), 0);
    @(negedge clk);
    chk(!beat_valid_o && !done_o, "R10 no late done", AW'({beat_valid_o, done_o}), 0);
    launch(32'h6000, 7, 0, 32'h0, 1'b0);
    walk(32'h6000, 7, 0, 32'h0, 1'b0);

    // R7: cyclic wrap, no done
    launch(32'h4000, 7, 1, 32'h20, 1'b1);
    beat_ready_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      logic [AW-1:0] e;
      e = AW'(32'h4000 + (i % 2) * 32'h20);
      chk(beat_valid_o && addr_o == e && !done_o, "R7 cyclic wrap", addr_o, e);
      @(negedge clk);
    end
    beat_ready_i = 1'b0;
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(!beat_valid_o && !done_o, "R10 abort cyclic", AW'({beat_valid_o, done_o}), 0);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule